// File: doc/BRIEF.md
# CPU-side PRG bank mapper

This block sits in a cartridge memory controller and turns CPU bus addresses into a physical address for the program memories behind it. Two write-only registers set its state. A bank register holds a bank number, an expansion flag and a RAM redirect flag. A mode register selects the bank size and the nametable mirroring.

From the CPU address and those registers, the block produces one program memory address. It also raises exactly one of three chip selects: one for the program ROM, one for the 8 KiB work RAM and one for the 128 KiB secondary RAM. The switchable window can be 16 KiB or 32 KiB. In 16 KiB mode the upper 16 KiB is fixed to the first bank of the main ROM. The expansion flag is ROM address bit 20, which places the expansion ROM in the upper 1 MiB of a 2 MiB space.

The block also chooses which PPU address line drives the nametable RAM's A10 pin. Every output is registered.

Top module: `prg_bank_mapper`

## Requirements
- R1: After the synchronous reset, all three selects, the address and the A10 output are 0 while reset is held. Both registers read as 0 afterwards, which means bank 0, ROM, main half, 16 KiB mode and vertical mirroring.
- R2: A write strobe with address exactly $5000 loads the bank register. Data bit 7 is the RAM flag, bit 6 is the expansion flag and bits 5..0 are the bank number. A write strobe with address exactly $5200 loads the mode register. Data bit 2 is the size flag (1 = 32 KiB) and bit 0 is the mirroring flag (1 = horizontal). Other data bits and writes to any other address change neither register.
- R3: In 16 KiB mode with the RAM flag clear, an access to $8000-$BFFF selects ROM at address {E, P[5:0], A13..A0}.
- R4: In 16 KiB mode, an access to $C000-$FFFF selects ROM at address {7'b0, A13..A0}, whatever the values of E and the RAM flag.
- R5: In 32 KiB mode with the RAM flag clear, an access to $8000-$FFFF selects ROM at address {E, P[5:1], A14..A0}. P[0] has no effect.
- R6: With the RAM flag set, the switchable window selects the secondary RAM and not the ROM, and E has no effect. The window is $8000-$BFFF in 16 KiB mode and $8000-$FFFF in 32 KiB mode. The address is {P[2:0], A13..A0} in 16 KiB mode and {P[2:1], A14..A0} in 32 KiB mode, and address bits 20..17 are 0.
- R7: An access to $6000-$7FFF selects the work RAM at address A12..A0, with all upper address bits 0.
- R8: An access below $6000 raises no select and gives address 0. At most one select is high at any time.
- R9: The A10 output follows PPU A10 when the mirroring flag is 0 and PPU A11 when it is 1.
- R10: Each output is registered. It reflects the inputs sampled at the previous rising edge and keeps its old value until that edge. An access presented in the cycle after a register write edge already uses the new register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, active high |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_addr | output | 21 | Program memory address |
| rom_cs | output | 1 | Program ROM select |
| wram_cs | output | 1 | Work RAM select |
| sram_cs | output | 1 | Secondary RAM select |
| ciram_a10 | output | 1 | Nametable RAM A10 |

## Verification
A register write takes effect at the edge that samples the strobe. An access presented at the next falling edge is translated at the following rising edge. Its address, selects and A10 are therefore due one cycle after the access is presented. The bench drives each access at a falling edge and compares at the next falling edge, half a period clear of the capture edge. One directed case also samples mid-cycle, before the capture edge, to confirm that the outputs still show the previous cycle's result.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int BANK_W     = 6;
  localparam int DATA_W     = 8;
  localparam int BIT_RAM    = 7;
  localparam int BIT_EXP    = 6;
  localparam int BIT_SIZE   = 2;
  localparam int BIT_MIRROR = 0;

  typedef struct packed {
    logic              ram_sel;
    logic              exp_sel;
    logic [BANK_W-1:0] num;
  } bank_reg_t;

  typedef struct packed {
    logic size32;
    logic mirror_h;
  } mode_reg_t;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter logic [15:0] BANK_ADDR = 16'h5000,
  parameter logic [15:0] MODE_ADDR = 16'h5200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  output bank_reg_t         bank_q,
  output mode_reg_t         mode_q
);
  logic hit_bank, hit_mode;

  assign hit_bank = cpu_wr && (cpu_addr == BANK_ADDR[CPU_AW-1:0]);
  assign hit_mode = cpu_wr && (cpu_addr == MODE_ADDR[CPU_AW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      mode_q <= '0;
    end else begin
      if (hit_bank) begin
        bank_q.ram_sel <= cpu_wdata[BIT_RAM];
        bank_q.exp_sel <= cpu_wdata[BIT_EXP];
        bank_q.num     <= cpu_wdata[BANK_W-1:0];
      end
      if (hit_mode) begin
        mode_q.size32   <= cpu_wdata[BIT_SIZE];
        mode_q.mirror_h <= cpu_wdata[BIT_MIRROR];
      end
    end
  end
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_bank_pkg::*;
#(
  parameter int CPU_AW  = 16,
  parameter int SRAM_AW = 17,
  localparam int WIN_AW  = CPU_AW - 2,
  localparam int WRAM_AW = CPU_AW - 3,
  localparam int ROM_AW  = 1 + BANK_W + WIN_AW,
  localparam int SRB     = SRAM_AW - WIN_AW
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  bank_reg_t         bank,
  input  mode_reg_t         mode,
  output logic [ROM_AW-1:0] addr,
  output logic              rom_cs,
  output logic              wram_cs,
  output logic              sram_cs
);
  logic               in_prg, in_wram, in_window;
  logic [ROM_AW-1:0]  rom16, rom32, fixed_lo;
  logic [SRAM_AW-1:0] sram16, sram32;

  assign in_prg    = cpu_addr[CPU_AW-1];
  assign in_wram   = (cpu_addr[CPU_AW-1:CPU_AW-3] == 3'b011);
  assign in_window = mode.size32 || !cpu_addr[WIN_AW];

  assign rom16    = {bank.exp_sel, bank.num, cpu_addr[WIN_AW-1:0]};
  assign rom32    = {bank.exp_sel, bank.num[BANK_W-1:1], cpu_addr[WIN_AW:0]};
  assign fixed_lo = ROM_AW'(cpu_addr[WIN_AW-1:0]);
  assign sram16   = {bank.num[SRB-1:0], cpu_addr[WIN_AW-1:0]};
  assign sram32   = {bank.num[SRB-1:1], cpu_addr[WIN_AW:0]};

  always_comb begin
    addr    = '0;
    rom_cs  = 1'b0;
    wram_cs = 1'b0;
    sram_cs = 1'b0;
    if (in_prg) begin
      if (!in_window) begin
        rom_cs = 1'b1;
        addr   = fixed_lo;
      end else if (bank.ram_sel) begin
        sram_cs = 1'b1;
        addr    = mode.size32 ? ROM_AW'(sram32) : ROM_AW'(sram16);
      end else begin
        rom_cs = 1'b1;
        addr   = mode.size32 ? rom32 : rom16;
      end
    end else if (in_wram) begin
      wram_cs = 1'b1;
      addr    = ROM_AW'(cpu_addr[WRAM_AW-1:0]);
    end
  end
endmodule

// File: rtl/prg_mirror_sel.sv
module prg_mirror_sel
  import prg_bank_pkg::*;
(
  input  mode_reg_t mode,
  input  logic      ppu_a10,
  input  logic      ppu_a11,
  output logic      ciram_a10
);
  assign ciram_a10 = mode.mirror_h ? ppu_a11 : ppu_a10;
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_bank_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter int          SRAM_AW   = 17,
  parameter logic [15:0] BANK_ADDR = 16'h5000,
  parameter logic [15:0] MODE_ADDR = 16'h5200,
  localparam int PRG_AW = 1 + BANK_W + CPU_AW - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              rom_cs,
  output logic              wram_cs,
  output logic              sram_cs,
  output logic              ciram_a10
);
  bank_reg_t         bank_q;
  mode_reg_t         mode_q;
  logic [PRG_AW-1:0] addr_d;
  logic              rom_d, wram_d, sram_d, a10_d;

  prg_bank_regs #(
    .CPU_AW(CPU_AW), .BANK_ADDR(BANK_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .bank_q(bank_q), .mode_q(mode_q)
  );

  prg_window_decode #(.CPU_AW(CPU_AW), .SRAM_AW(SRAM_AW)) u_dec (
    .cpu_addr(cpu_addr), .bank(bank_q), .mode(mode_q), .addr(addr_d),
    .rom_cs(rom_d), .wram_cs(wram_d), .sram_cs(sram_d)
  );

  prg_mirror_sel u_mir (
    .mode(mode_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ciram_a10(a10_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr  <= '0;
      rom_cs    <= 1'b0;
      wram_cs   <= 1'b0;
      sram_cs   <= 1'b0;
      ciram_a10 <= 1'b0;
    end else begin
      prg_addr  <= addr_d;
      rom_cs    <= rom_d;
      wram_cs   <= wram_d;
      sram_cs   <= sram_d;
      ciram_a10 <= a10_d;
    end
  end
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk
  import prg_bank_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter int          PRG_AW    = 21,
  parameter logic [15:0] BANK_ADDR = 16'h5000,
  localparam int WIN_AW = CPU_AW - 2
) (
  input logic              clk,
  input logic              rst,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_wr,
  input logic              ppu_a10,
  input logic              ppu_a11,
  input logic [PRG_AW-1:0] prg_addr,
  input logic              rom_cs,
  input logic              wram_cs,
  input logic              sram_cs,
  input logic              ciram_a10,
  input bank_reg_t         bank_q,
  input mode_reg_t         mode_q
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, wram_cs, sram_cs}));

  p_low_none_r8: assert property (@(posedge clk) disable iff (rst)
    live && $past(cpu_addr[CPU_AW-1:CPU_AW-3] < 3'b011)
    |-> !rom_cs && !wram_cs && !sram_cs && prg_addr == '0);

  p_bank_load_r2: assert property (@(posedge clk) disable iff (rst)
    live && $past(cpu_wr && cpu_addr == BANK_ADDR[CPU_AW-1:0])
    |-> bank_q == $past({cpu_wdata[BIT_RAM], cpu_wdata[BIT_EXP], cpu_wdata[BANK_W-1:0]}));

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
    live && !$past(cpu_wr && cpu_addr == BANK_ADDR[CPU_AW-1:0]) |-> $stable(bank_q));

  p_win16_r3: assert property (@(posedge clk) disable iff (rst)
    live && $past(cpu_addr[CPU_AW-1:WIN_AW] == 2'b10 && !mode_q.size32 && !bank_q.ram_sel)
    |-> rom_cs && prg_addr[PRG_AW-1:WIN_AW] == $past({bank_q.exp_sel, bank_q.num}));

  p_fixed_hi_r4: assert property (@(posedge clk) disable iff (rst)
    live && $past(cpu_addr[CPU_AW-1:WIN_AW] == 2'b11 && !mode_q.size32)
    |-> rom_cs && prg_addr == PRG_AW'($past(cpu_addr[WIN_AW-1:0])));

  p_win32_r5: assert property (@(posedge clk) disable iff (rst)
    live && $past(cpu_addr[CPU_AW-1] && mode_q.size32 && !bank_q.ram_sel)
    |-> rom_cs && prg_addr[WIN_AW:0] == $past(cpu_addr[WIN_AW:0]));

  p_sram_top_r6: assert property (@(posedge clk) disable iff (rst)
    sram_cs |-> prg_addr[PRG_AW-1:17] == '0);

  p_wram_r7: assert property (@(posedge clk) disable iff (rst)
    live && $past(cpu_addr[CPU_AW-1:CPU_AW-3] == 3'b011)
    |-> wram_cs && prg_addr == PRG_AW'($past(cpu_addr[CPU_AW-4:0])));

  p_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    live |-> ciram_a10 == ($past(mode_q.mirror_h) ? $past(ppu_a11) : $past(ppu_a10)));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .CPU_AW(CPU_AW), .PRG_AW(PRG_AW), .BANK_ADDR(BANK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
  .prg_addr(prg_addr), .rom_cs(rom_cs), .wram_cs(wram_cs),
  .sram_cs(sram_cs), .ciram_a10(ciram_a10), .bank_q(bank_q), .mode_q(mode_q)
);

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic        ppu_a10, ppu_a11;
  logic [20:0] prg_addr;
  logic        rom_cs, wram_cs, sram_cs, ciram_a10;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  prg_bank_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .prg_addr(prg_addr), .rom_cs(rom_cs), .wram_cs(wram_cs),
    .sram_cs(sram_cs), .ciram_a10(ciram_a10)
  );

  typedef struct packed {
    logic [7:0]  bank;
    logic [7:0]  mode;
    logic [15:0] addr;
    logic        p10;
    logic        p11;
    logic [20:0] eaddr;
    logic [2:0]  ecs;     // {rom, wram, sram}
    logic        ea10;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 16'h8000, 1'b1, 1'b0, 21'h000000, 3'b100, 1'b1}, // R3
    '{8'h05, 8'h00, 16'hA123, 1'b0, 1'b1, 21'h016123, 3'b100, 1'b0}, // R3
    '{8'h45, 8'h00, 16'hBFFF, 1'b1, 1'b1, 21'h117FFF, 3'b100, 1'b1}, // R3
    '{8'hFF, 8'h00, 16'hC456, 1'b0, 1'b1, 21'h000456, 3'b100, 1'b0}, // R4
    '{8'h47, 8'h04, 16'h8001, 1'b1, 1'b0, 21'h118001, 3'b100, 1'b1}, // R5
    '{8'h46, 8'h04, 16'hC001, 1'b0, 1'b0, 21'h11C001, 3'b100, 1'b0}, // R5
    '{8'h2A, 8'h05, 16'hFFFF, 1'b1, 1'b0, 21'h0AFFFF, 3'b100, 1'b0}, // R5
    '{8'h00, 8'h01, 16'h8000, 1'b0, 1'b1, 21'h000000, 3'b100, 1'b1}, // R9
    '{8'h85, 8'h00, 16'h9234, 1'b0, 1'b0, 21'h015234, 3'b001, 1'b0}, // R6
    '{8'hCF, 8'h00, 16'hA000, 1'b0, 1'b0, 21'h01E000, 3'b001, 1'b0}, // R6
    '{8'h87, 8'h04, 16'hC321, 1'b0, 1'b0, 21'h01C321, 3'b001, 1'b0}, // R6
    '{8'h80, 8'h04, 16'h8000, 1'b0, 1'b0, 21'h000000, 3'b001, 1'b0}, // R6
    '{8'h45, 8'h00, 16'h6000, 1'b0, 1'b0, 21'h000000, 3'b010, 1'b0}, // R7
    '{8'h45, 8'h00, 16'h7FFF, 1'b0, 1'b0, 21'h001FFF, 3'b010, 1'b0}, // R7
    '{8'h45, 8'h00, 16'h5FFF, 1'b0, 1'b0, 21'h000000, 3'b000, 1'b0}, // R8
    '{8'h45, 8'h00, 16'h0000, 1'b0, 1'b0, 21'h000000, 3'b000, 1'b0}, // R8
    '{8'h45, 8'h00, 16'h5000, 1'b0, 1'b0, 21'h000000, 3'b000, 1'b0}  // R8
  };

  function automatic string vtag(int i);
    if (i < 3)       return "R3";
    else if (i == 3) return "R4";
    else if (i < 7)  return "R5";
    else if (i == 7) return "R9";
    else if (i < 12) return "R6";
    else if (i < 14) return "R7";
    else             return "R8";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_out(string tag, logic [20:0] ea, logic [2:0] ecs, logic ea10);
    chk(tag, "prg_addr", 32'(prg_addr), 32'(ea));
    chk(tag, "selects", 32'({rom_cs, wram_cs, sram_cs}), 32'(ecs));
    chk(tag, "ciram_a10", 32'(ciram_a10), 32'(ea10));
  endtask

  task automatic wr_reg(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic access(logic [15:0] a, logic p10, logic p11);
    @(negedge clk);
    cpu_addr = a; ppu_a10 = p10; ppu_a11 = p11; cpu_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_addr = 16'h8000; cpu_wdata = 8'h00; cpu_wr = 1'b0;
    ppu_a10 = 1'b1; ppu_a11 = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check_out("R1", 21'h0, 3'b000, 1'b0);
    rst = 1'b0;
    // R1: registers cleared -> bank 0, 16 KiB, vertical
    access(16'hA000, 1'b0, 1'b1);
    check_out("R1", 21'h002000, 3'b100, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr_reg(16'h5000, VEC[i].bank);
      wr_reg(16'h5200, VEC[i].mode);
      access(VEC[i].addr, VEC[i].p10, VEC[i].p11);
      check_out(vtag(i), VEC[i].eaddr, VEC[i].ecs, VEC[i].ea10);
    end

    // R2: writes to neighbouring or window addresses do not touch the bank register
    wr_reg(16'h5000, 8'h05);
    wr_reg(16'h5200, 8'h00);
    wr_reg(16'h5001, 8'hFF);
    wr_reg(16'h8000, 8'h3F);
    wr_reg(16'hD000, 8'hC0);
    access(16'hA123, 1'b0, 1'b0);
    check_out("R2", 21'h016123, 3'b100, 1'b0);
    // R2: mode register alias address ignored
    wr_reg(16'h5201, 8'h05);
    access(16'hC001, 1'b1, 1'b0);
    check_out("R2", 21'h000001, 3'b100, 1'b1);
    // R2: mode data bits other than 2 and 0 ignored
    wr_reg(16'h5200, 8'hFA);
    access(16'hC001, 1'b1, 1'b0);
    check_out("R2", 21'h000001, 3'b100, 1'b1);

    // R10: output holds until the capture edge, then uses the new bank at once
    wr_reg(16'h5000, 8'h09);
    cpu_addr = 16'h8000;
    #5;
    chk("R10", "rom_cs before edge", 32'(rom_cs), 32'd0);
    @(negedge clk);
    chk("R10", "prg_addr after edge", 32'(prg_addr), 32'h024000);
    chk("R10", "rom_cs after edge", 32'(rom_cs), 32'd1);

    // R1: reset in mid-run clears both registers
    wr_reg(16'h5000, 8'h45);
    wr_reg(16'h5200, 8'h05);
    @(negedge clk);
    rst = 1'b1; cpu_addr = 16'h9000; ppu_a10 = 1'b1; ppu_a11 = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R1", 21'h0, 3'b000, 1'b0);
    rst = 1'b0;
    access(16'h9000, 1'b1, 1'b0);
    check_out("R1", 21'h001000, 3'b100, 1'b1);

    summary();
    $finish;
  end
endmodule